// File: doc/BRIEF.md
# E2 Frame Alignment Detector

This block is the receive framer for an 8.448 Mb/s second-order tributary. It takes a serial bit stream with a clock enable. Each enabled cycle carries one line bit. The block finds the 10-bit alignment word, confirms it, and then tracks the frame. A frame holds four sets of equal length, and the word opens the first set. Once locked, the block gives downstream demultiplexing logic the set number and the bit position of every bit. It marks the first bit of each frame with a pulse.

The block also watches the stream for faults. It declares loss of frame when the alignment word keeps arriving corrupted. It flags an unframed all-ones alarm signal (AIS) by counting zeros over a free-running frame-length window. It picks the far-end alarm bit out of each aligned frame and reports it only once the bit has been seen twice in a row.

Top module: `e2_frame_align`

## Requirements
- R1: After reset, lof_o=1, ais_o=0, rai_o=0, sof_o=0, set_o=0 and pos_o=0.
- R2: A cycle with en_i=0 is not a line bit. It changes no position, alignment, AIS or remote alarm state, and sof_o is 0 in that cycle.
- R3: While aligned, set_o and pos_o give the position of the bit on data_i. set_o=0 is the set that starts with the alignment word. pos_o runs from 0 to SET_LEN-1 and then wraps, stepping set_o through 0..NUM_SETS-1.
- R4: The alignment word is 1111010000, and its leftmost bit is received first. While out of frame, lof_o falls on the enabled edge that completes the SYNC_OK-th (default 3) consecutive correct word at one-frame spacing.
- R5: While confirming, a single errored word at the expected place cancels the candidate. The search restarts, and another SYNC_OK fresh words are needed.
- R6: While aligned, lof_o rises on the edge that completes the LOF_ERR-th (default 4) consecutive errored word. A correct word resets the error run.
- R7: While aligned and with en_i=1, sof_o is 1 exactly in the cycle that presents bit 0 of set 0.
- R8: AIS windows are successive runs of SET_LEN*NUM_SETS enabled bits, counted from reset. On the last bit of a window, ais_o becomes 1 if the window held fewer than AIS_ZEROS (default 3) zeros, and 0 otherwise. It holds its value between window ends.
- R9: While aligned, the bit right after the alignment word (set 0, pos FAW_LEN) is sampled once per frame. rai_o takes that value only after RAI_CONFIRM (default 2) consecutive frames agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Line bit valid this cycle |
| data_i | input | 1 | Serial line bit |
| lof_o | output | 1 | Loss of frame (1 = not aligned) |
| sof_o | output | 1 | First bit of frame on data_i |
| set_o | output | $clog2(NUM_SETS) | Set index of current bit |
| pos_o | output | $clog2(SET_LEN) | Bit index within set |
| ais_o | output | 1 | All-ones alarm |
| rai_o | output | 1 | Confirmed remote alarm bit |

## Verification
The bench builds the block with SET_LEN=24 and leaves the other parameters at their defaults. This gives a 96-bit frame, so dozens of complete frames fit in a short run. Each frame uses a generated payload that never imitates the alignment word. The bench sweeps every position of a frame and checks set, position and start-of-frame against arithmetic on the bit index. The short frame also reaches the exact edges of acquisition, of an aborted confirmation, of the error run that drops alignment, and of the AIS threshold (windows with two and with three zeros).

// File: rtl/e2fa_pkg.sv
package e2fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } align_st_e;
endpackage

// File: rtl/e2fa_locator.sv
module e2fa_locator
  import e2fa_pkg::*;
#(
  parameter int SET_LEN  = 212,
  parameter int NUM_SETS = 4,
  parameter int FAW_LEN  = 10,
  parameter logic [FAW_LEN-1:0] FAW = 10'b1111010000,
  parameter int SYNC_OK  = 3,
  parameter int LOF_ERR  = 4,
  localparam int POS_W = $clog2(SET_LEN),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             data_i,
  output logic             lof_o,
  output logic             sof_o,
  output logic             rai_stb_o,
  output logic [SET_W-1:0] set_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int OK_W  = $clog2(SYNC_OK + 1);
  localparam int ERR_W = $clog2(LOF_ERR + 1);

  align_st_e          st_q, st_d;
  logic [FAW_LEN-2:0] hist_q;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic [SET_W-1:0]   set_q, set_d;
  logic [OK_W-1:0]    ok_q, ok_d;
  logic [ERR_W-1:0]   err_q, err_d;
  logic               match, at_chk;

  assign match  = ({hist_q, data_i} == FAW);
  assign at_chk = (set_q == '0) && (pos_q == POS_W'(FAW_LEN - 1));

  always_comb begin
    st_d  = st_q;
    ok_d  = ok_q;
    err_d = err_q;
    if (pos_q == POS_W'(SET_LEN - 1)) begin
      pos_d = '0;
      set_d = (set_q == SET_W'(NUM_SETS - 1)) ? '0 : set_q + 1'b1;
    end else begin
      pos_d = pos_q + 1'b1;
      set_d = set_q;
    end
    unique case (st_q)
      ST_HUNT: if (match) begin
        st_d  = ST_CONFIRM;
        ok_d  = OK_W'(1);
        pos_d = POS_W'(FAW_LEN);
        set_d = '0;
      end
      ST_CONFIRM: if (at_chk) begin
        if (!match) begin
          st_d = ST_HUNT;
        end else if (ok_q == OK_W'(SYNC_OK - 1)) begin
          st_d  = ST_SYNC;
          err_d = '0;
        end else begin
          ok_d = ok_q + 1'b1;
        end
      end
      ST_SYNC: if (at_chk) begin
        if (match) begin
          err_d = '0;
        end else if (err_q == ERR_W'(LOF_ERR - 1)) begin
          st_d  = ST_HUNT;
          err_d = '0;
        end else begin
          err_d = err_q + 1'b1;
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      hist_q <= '0;
      pos_q  <= '0;
      set_q  <= '0;
      ok_q   <= '0;
      err_q  <= '0;
    end else if (en_i) begin
      st_q   <= st_d;
      hist_q <= {hist_q[FAW_LEN-3:0], data_i};
      pos_q  <= pos_d;
      set_q  <= set_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
    end
  end

  assign lof_o     = (st_q != ST_SYNC);
  assign sof_o     = en_i && (st_q == ST_SYNC) && (set_q == '0) && (pos_q == '0);
  assign rai_stb_o = en_i && (st_q == ST_SYNC) && (set_q == '0) && (pos_q == POS_W'(FAW_LEN));
  assign set_o     = set_q;
  assign pos_o     = pos_q;

  a_r3_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q < POS_W'(SET_LEN)) && (set_q <= SET_W'(NUM_SETS - 1)));
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pos_q) && $stable(set_q) && $stable(st_q));
  a_r4_sync_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SYNC && $past(st_q) != ST_SYNC) |->
      ($past(st_q) == ST_CONFIRM && $past(ok_q) == OK_W'(SYNC_OK - 1)));
  a_r6_lof_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT && $past(st_q) == ST_SYNC) |-> $past(err_q) == ERR_W'(LOF_ERR - 1));
  a_r7_sof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);
endmodule

// File: rtl/e2fa_ais.sv
module e2fa_ais #(
  parameter int FRAME_LEN = 848,
  parameter int AIS_ZEROS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic data_i,
  output logic ais_o
);
  localparam int WIN_W = $clog2(FRAME_LEN);
  localparam int ZC_W  = $clog2(AIS_ZEROS + 1);

  logic [WIN_W-1:0] win_q;
  logic [ZC_W-1:0]  zc_q, zc_n;
  logic             last, ais_q;

  assign last = (win_q == WIN_W'(FRAME_LEN - 1));
  assign zc_n = (!data_i && zc_q < ZC_W'(AIS_ZEROS)) ? zc_q + 1'b1 : zc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      zc_q  <= '0;
      ais_q <= 1'b0;
    end else if (en_i) begin
      if (last) begin
        win_q <= '0;
        zc_q  <= '0;
        ais_q <= (zc_n < ZC_W'(AIS_ZEROS));
      end else begin
        win_q <= win_q + 1'b1;
        zc_q  <= zc_n;
      end
    end
  end

  assign ais_o = ais_q;

  a_r8_ais_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && last) |=> $stable(ais_q));
  a_r8_zero_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_q <= ZC_W'(AIS_ZEROS));
endmodule

// File: rtl/e2fa_rai.sv
module e2fa_rai #(
  parameter int RAI_CONFIRM = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic bit_i,
  output logic rai_o
);
  localparam int CNT_W = $clog2(RAI_CONFIRM + 1);

  logic             cand_q, rai_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign cnt_n = (bit_i != cand_q) ? CNT_W'(1) :
                 (cnt_q < CNT_W'(RAI_CONFIRM)) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= 1'b0;
      cnt_q  <= '0;
      rai_q  <= 1'b0;
    end else if (stb_i) begin
      cand_q <= bit_i;
      cnt_q  <= cnt_n;
      if (cnt_n >= CNT_W'(RAI_CONFIRM)) rai_q <= bit_i;
    end
  end

  assign rai_o = rai_q;

  a_r9_rai_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(rai_q));
  a_r9_rai_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rai_q != $past(rai_q)) |-> (rai_q == $past(bit_i)) && ($past(cand_q) == $past(bit_i)));
endmodule

// File: rtl/e2_frame_align.sv
module e2_frame_align #(
  parameter int SET_LEN     = 212,
  parameter int NUM_SETS    = 4,
  parameter int FAW_LEN     = 10,
  parameter logic [FAW_LEN-1:0] FAW = 10'b1111010000,
  parameter int SYNC_OK     = 3,
  parameter int LOF_ERR     = 4,
  parameter int AIS_ZEROS   = 3,
  parameter int RAI_CONFIRM = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        data_i,
  output logic                        lof_o,
  output logic                        sof_o,
  output logic [$clog2(NUM_SETS)-1:0] set_o,
  output logic [$clog2(SET_LEN)-1:0]  pos_o,
  output logic                        ais_o,
  output logic                        rai_o
);
  localparam int FRAME_LEN = SET_LEN * NUM_SETS;

  logic rai_stb;

  e2fa_locator #(
    .SET_LEN (SET_LEN),
    .NUM_SETS(NUM_SETS),
    .FAW_LEN (FAW_LEN),
    .FAW     (FAW),
    .SYNC_OK (SYNC_OK),
    .LOF_ERR (LOF_ERR)
  ) u_loc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .data_i   (data_i),
    .lof_o    (lof_o),
    .sof_o    (sof_o),
    .rai_stb_o(rai_stb),
    .set_o    (set_o),
    .pos_o    (pos_o)
  );

  e2fa_ais #(
    .FRAME_LEN(FRAME_LEN),
    .AIS_ZEROS(AIS_ZEROS)
  ) u_ais (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .data_i(data_i),
    .ais_o (ais_o)
  );

  e2fa_rai #(
    .RAI_CONFIRM(RAI_CONFIRM)
  ) u_rai (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (rai_stb),
    .bit_i (data_i),
    .rai_o (rai_o)
  );

  a_r7_sof_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> !lof_o && en_i);
endmodule

// File: tb/e2_frame_align_tb.sv
`timescale 1ns/1ps
module e2_frame_align_tb;
  localparam int SL = 24;
  localparam int NS = 4;
  localparam int FL = SL * NS;
  localparam logic [9:0] WORD = 10'b1111010000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, data = 1'b0;
  logic lof_o, sof_o, ais_o, rai_o;
  logic [1:0] set_o;
  logic [4:0] pos_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic pre_sof, pre_lof, pre_ais;
  logic [1:0] pre_set;
  logic [4:0] pre_pos;
  logic w_pre_lof, w_post_lof, w_post_rai, w_pre_ais, w_post_ais;

  always #2.5 clk = ~clk;

  e2_frame_align #(.SET_LEN(SL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .data_i(data),
    .lof_o(lof_o), .sof_o(sof_o), .set_o(set_o), .pos_o(pos_o),
    .ais_o(ais_o), .rai_o(rai_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic e);
    @(negedge clk);
    data = b; en = e;
    #1;
    pre_sof = sof_o; pre_lof = lof_o; pre_ais = ais_o;
    pre_set = set_o; pre_pos = pos_o;
    @(posedge clk);
    #1;
  endtask

  function automatic logic frame_bit(input int i, input logic rai, input logic cor);
    if (i < 10) return WORD[9-i] ^ (cor && i == 9);
    if (i == 10) return rai;
    if (i == 11) return 1'b1;
    return logic'(i % 2);
  endfunction

  task automatic send_frame(input logic rai, input logic cor, input int watch);
    for (int i = 0; i < FL; i++) begin
      drive(frame_bit(i, rai, cor), 1'b1);
      if (i == watch) begin
        w_pre_lof = pre_lof; w_post_lof = lof_o; w_post_rai = rai_o;
        w_pre_ais = pre_ais; w_post_ais = ais_o;
      end
    end
  endtask

  task automatic send_ones(input int nz);
    for (int i = 0; i < FL; i++) begin
      drive(!(i >= 40 && i < 40 + nz), 1'b1);
      if (i == FL - 1) begin w_pre_ais = pre_ais; w_post_ais = ais_o; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [4:0] hold_pos;
    logic [1:0] hold_set;
    int idle_bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 lof", lof_o, 1); chk("R1 ais", ais_o, 0); chk("R1 rai", rai_o, 0);
    chk("R1 sof", sof_o, 0); chk("R1 set", set_o, 0); chk("R1 pos", pos_o, 0);
    rst_n = 1'b1;

    // acquisition
    send_frame(1'b0, 1'b0, 9);
    chk("R4 f0 lof", w_post_lof, 1);
    send_frame(1'b0, 1'b0, 10);
    chk("R4 f1 lof", w_post_lof, 1);
    send_frame(1'b1, 1'b0, 9);
    chk("R4 lof before third", w_pre_lof, 1);
    chk("R4 lof after third", w_post_lof, 0);
    chk("R9 first sample", rai_o, 0);

    // full position sweep, rai second frame
    for (int i = 0; i < FL; i++) begin
      drive(frame_bit(i, 1'b1, 1'b0), 1'b1);
      chk("R3 set", pre_set, i / SL);
      chk("R3 pos", pre_pos, i % SL);
      chk("R7 sof", pre_sof, (i == 0) ? 1 : 0);
      if (i == 10) chk("R9 confirmed 1", rai_o, 1);
    end
    send_frame(1'b0, 1'b0, 10);
    chk("R9 single 0 ignored", w_post_rai, 1);
    send_frame(1'b0, 1'b0, 10);
    chk("R9 confirmed 0", w_post_rai, 0);

    // idle cycles interleaved
    idle_bad = 0;
    for (int i = 0; i < FL; i++) begin
      drive(frame_bit(i, 1'b1, 1'b0), 1'b1);
      hold_pos = pos_o; hold_set = set_o;
      drive(1'b1, 1'b0);
      if (pos_o != hold_pos || set_o != hold_set || pre_sof) idle_bad++;
      drive(1'b0, 1'b0);
      if (pos_o != hold_pos || set_o != hold_set || pre_sof) idle_bad++;
    end
    chk("R2 idle holds position", idle_bad, 0);
    chk("R2 idle keeps lof", lof_o, 0);
    chk("R2 idle rai untouched", rai_o, 0);
    drive(1'b1, 1'b0);
    chk("R2 no sof when idle", pre_sof, 0);
    chk("R2 position at frame start", pre_pos, 0);

    // loss of frame
    repeat (3) send_frame(1'b0, 1'b1, 9);
    chk("R6 three errors hold", w_post_lof, 0);
    send_frame(1'b0, 1'b0, 9);
    repeat (3) send_frame(1'b0, 1'b1, 9);
    chk("R6 run restarted", w_post_lof, 0);
    send_frame(1'b0, 1'b1, 9);
    chk("R6 lof before fourth", w_pre_lof, 0);
    chk("R6 lof after fourth", w_post_lof, 1);

    // aborted confirmation
    send_frame(1'b0, 1'b0, 9);
    send_frame(1'b0, 1'b1, 9);
    send_frame(1'b0, 1'b0, 9);
    send_frame(1'b0, 1'b0, 9);
    chk("R5 candidate dropped", w_post_lof, 1);
    send_frame(1'b0, 1'b0, 9);
    chk("R5 reacquire", w_post_lof, 0);
    chk("R8 no ais on framed", ais_o, 0);

    // AIS threshold
    send_ones(0);
    chk("R8 ais before window end", w_pre_ais, 0);
    chk("R8 ais all ones", w_post_ais, 1);
    send_ones(2);
    chk("R8 two zeros keep ais", w_post_ais, 1);
    send_ones(3);
    chk("R8 three zeros clear ais", w_post_ais, 0);

    finish_run();
  end
endmodule